// File: doc/BRIEF.md
# Multi-Mode Iterative Integer Divider

This block divides a dividend held in a register pair by a 16-bit divisor for a 16-bit processor core. One datapath covers five kinds of division: unsigned and signed 16/16, unsigned and signed 32/16, and signed fractional 16/16 where both operands are Q15 values. A one-cycle `start` pulse latches the operands, the mode and the preserve choice. The division then runs for exactly six clock steps. Each step retires three quotient bits from an unrolled restoring-division chain.

When the sixth step ends, the block presents a 16-bit quotient and a 16-bit remainder together with four flags, and pulses `done` for one cycle. With `preserve` set, the normal `quotient` and `remainder` outputs keep their old values and the result goes to a separate pair of outputs instead. Requests that arrive while a division is running are dropped.

Top module: `divIterative`

## Requirements
- R1: Mode code 0 is unsigned 16/16 (dividend = `dividendLo`), code 2 is unsigned 32/16 (dividend = {`dividendHi`,`dividendLo`}), and codes 5 to 7 behave as code 0. The quotient is floor(dividend/divisor) and the remainder is dividend minus quotient times divisor.
- R2: Mode code 1 is signed 16/16 and code 3 is signed 32/16, using two's complement operands. The quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R3: Mode code 4 is fractional: the dividend is signed `dividendLo` times 2^15 and the divisor is signed. The quotient is the truncated Q15 result and the remainder follows R2.
- R4: `busy` is high from the clock edge that accepts `start` until the sixth edge after it. `done` is high for exactly the one cycle that follows that sixth edge.
- R5: `flagOv` is set when the divisor is zero or the quotient does not fit in 16 bits. The range is 0..65535 for unsigned modes and -32768..32767 for signed modes. Quotient and remainder values are unspecified when `flagOv` is set.
- R6: When `flagOv` is clear, `flagN` equals quotient bit 15, `flagZ` is set exactly when the quotient is zero, and `flagC` is set exactly when the remainder is non-zero.
- R7: With `preserve` = 0 the result is written to `quotient`/`remainder` and `sideQuotient`/`sideRemainder` are left unchanged. With `preserve` = 1 the reverse applies. The flags are written in both cases, and no output changes at any other time.
- R8: A `start` pulse while `busy` is high is ignored: the running division finishes on its original schedule with its original operands.
- R9: After reset, `busy`, `done`, all result outputs and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; accepted only while idle |
| mode | input | 3 | Division kind, encoded as in R1 to R3 |
| preserve | input | 1 | Route the result to the side outputs (R7) |
| dividendHi | input | 16 | Upper dividend word (32/16 modes) |
| dividendLo | input | 16 | Lower dividend word |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient (preserve = 0) |
| remainder | output | 16 | Remainder (preserve = 0) |
| sideQuotient | output | 16 | Quotient (preserve = 1) |
| sideRemainder | output | 16 | Remainder (preserve = 1) |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Non-zero remainder flag |
| flagOv | output | 1 | Overflow or divide-by-zero flag |

## Verification
A wrong step count or a stuck counter shows up on the first division: `done` arrives before or after the sixth edge, or never arrives. A mistake in the partial remainder or in the shifted quotient bits spreads to every later bit, so it shows as a wrong quotient or remainder in the same `done` cycle. A sign or range error only appears for particular operand signs and magnitudes. The random mix of modes is therefore combined with directed edge cases at -32768/-1, division by zero, and fractional equal operands. Mis-routing under `preserve` shows up at the following completion as a changed `quotient` or a stale side output.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [2:0] {
    MODE_U16  = 3'd0,
    MODE_S16  = 3'd1,
    MODE_U32  = 3'd2,
    MODE_S32  = 3'd3,
    MODE_FRAC = 3'd4
  } divMode_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobes_t;
endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int STEPS = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes.load   = start && !busy;
    strobes.step   = busy;
    strobes.finish = busy && (stepCnt == CW'(STEPS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (strobes.finish) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else if (strobes.step) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W     = 16,
  parameter int STEPS = 6,
  parameter int BPS   = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  divMode_e     modeE,
  input  logic         preserve,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] sideQuotient,
  output logic [W-1:0] sideRemainder,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagOv
);
  localparam int QB  = STEPS * BPS;
  localparam int PAD = QB - W;
  localparam int DW  = 2 * W;

  // operand preparation (used on load)
  logic          isSigned, dvdNeg, dsrNeg, ovPre;
  logic [DW-1:0] dvdRaw, dvdMag;
  logic [W-1:0]  dsrMag;

  always_comb begin
    case (modeE)
      MODE_S16:           dvdRaw = {{W{dividendLo[W-1]}}, dividendLo};
      MODE_U32, MODE_S32: dvdRaw = {dividendHi, dividendLo};
      MODE_FRAC:          dvdRaw = {dividendLo[W-1], dividendLo, {(W-1){1'b0}}};
      default:            dvdRaw = {{W{1'b0}}, dividendLo};
    endcase
    isSigned = (modeE == MODE_S16) || (modeE == MODE_S32) || (modeE == MODE_FRAC);
    dvdNeg   = isSigned && dvdRaw[DW-1];
    dsrNeg   = isSigned && divisor[W-1];
    dvdMag   = dvdNeg ? (~dvdRaw + 1'b1) : dvdRaw;
    dsrMag   = dsrNeg ? (~divisor + 1'b1) : divisor;
    ovPre    = (dvdMag[DW-1:W] >= dsrMag);
  end

  // iteration state
  logic [W-1:0]  remR, dsrR;
  logic [QB-1:0] shR;
  logic          qNegR, rNegR, signedR, ovPreR, preserveR;

  logic [BPS:0][W-1:0]  remSt;
  logic [BPS:0][QB-1:0] shSt;

  assign remSt[0] = remR;
  assign shSt[0]  = shR;

  for (genvar g = 0; g < BPS; g++) begin : gStage
    logic [W:0] trial, diff;
    logic       ge;
    assign trial         = {remSt[g], shSt[g][QB-1]};
    assign diff          = trial - {1'b0, dsrR};
    assign ge            = (trial >= {1'b0, dsrR});
    assign remSt[g+1]    = ge ? diff[W-1:0] : trial[W-1:0];
    assign shSt[g+1]     = {shSt[g][QB-2:0], ge};
  end

  // result formation on the last step
  logic [W-1:0]   qMag, remFinal, qOut, rOut;
  logic [PAD-1:0] qHigh;
  logic           sgnOv, ovAll;

  always_comb begin
    qMag     = shSt[BPS][W-1:0];
    qHigh    = shSt[BPS][QB-1:W];
    remFinal = remSt[BPS];
    sgnOv    = signedR && (qNegR ? (qMag[W-1] && (|qMag[W-2:0])) : qMag[W-1]);
    ovAll    = ovPreR || (|qHigh) || sgnOv;
    qOut     = qNegR ? (~qMag + 1'b1) : qMag;
    rOut     = rNegR ? (~remFinal + 1'b1) : remFinal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR          <= '0;
      dsrR          <= '0;
      shR           <= '0;
      qNegR         <= 1'b0;
      rNegR         <= 1'b0;
      signedR       <= 1'b0;
      ovPreR        <= 1'b0;
      preserveR     <= 1'b0;
      quotient      <= '0;
      remainder     <= '0;
      sideQuotient  <= '0;
      sideRemainder <= '0;
      flagN         <= 1'b0;
      flagZ         <= 1'b0;
      flagC         <= 1'b0;
      flagOv        <= 1'b0;
    end else begin
      if (strobes.load) begin
        remR      <= {{PAD{1'b0}}, dvdMag[DW-1:QB]};
        shR       <= dvdMag[QB-1:0];
        dsrR      <= dsrMag;
        qNegR     <= dvdNeg ^ dsrNeg;
        rNegR     <= dvdNeg;
        signedR   <= isSigned;
        ovPreR    <= ovPre;
        preserveR <= preserve;
      end else if (strobes.step) begin
        remR <= remSt[BPS];
        shR  <= shSt[BPS];
      end
      if (strobes.finish) begin
        if (preserveR) begin
          sideQuotient  <= qOut;
          sideRemainder <= rOut;
        end else begin
          quotient  <= qOut;
          remainder <= rOut;
        end
        flagN  <= qOut[W-1];
        flagZ  <= (qOut == '0);
        flagC  <= (rOut != '0);
        flagOv <= ovAll;
      end
    end
  end
endmodule

// File: rtl/divIterative.sv
module divIterative
  import divPkg::*;
#(
  parameter int W     = 16,
  parameter int STEPS = 6,
  parameter int BPS   = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic         preserve,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] sideQuotient,
  output logic [W-1:0] sideRemainder,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagOv
);
  ctrlStrobes_t strobes;
  divMode_e     modeE;

  assign modeE = divMode_e'(mode);

  divControl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  divDatapath #(.W(W), .STEPS(STEPS), .BPS(BPS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeE(modeE),
    .preserve(preserve), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .sideQuotient(sideQuotient), .sideRemainder(sideRemainder),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagOv(flagOv)
  );
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int W     = 16,
  parameter int STEPS = 6
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         preserve,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagC,
  input logic         flagOv
);
  logic [7:0] busyLen;
  logic       presCap, zeroCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= '0;
      presCap <= 1'b0;
      zeroCap <= 1'b0;
    end else if (start && !busy) begin
      busyLen <= '0;
      presCap <= preserve;
      zeroCap <= (divisor == '0);
    end else if (busy) begin
      busyLen <= busyLen + 1'b1;
    end
  end

  // R4 and R8: a busy window lasts exactly STEPS edges, even with extra start pulses
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 8'(STEPS)));

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(quotient) |-> (done && !presCap));

  assert_hold_rem_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remainder) |-> (done && !presCap));

  assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroCap) |-> flagOv);

  assert_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !flagOv && !presCap) |->
      ((flagN == quotient[W-1]) && (flagZ == (quotient == '0)) &&
       (flagC == (remainder != '0))));
endmodule

bind divIterative divChecker #(.W(W), .STEPS(STEPS)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .preserve(preserve),
  .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
  .remainder(remainder), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
  .flagOv(flagOv)
);

// File: tb/divIterative_bench.sv
module divIterative_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        preserve = 1'b0;
  logic [15:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic        busy, done, flagN, flagZ, flagC, flagOv;
  logic [15:0] quotient, remainder, sideQuotient, sideRemainder;

  int checks = 0;
  int errors = 0;

  logic [15:0] archQ = '0, archR = '0, sideQ = '0, sideR = '0;
  bit          archKnown = 1'b1, sideKnown = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  divIterative u_divIterative (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .preserve(preserve),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .sideQuotient(sideQuotient), .sideRemainder(sideRemainder),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagOv(flagOv)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model from R1..R3, R5
  task automatic refDiv(input logic [2:0] m, input logic [15:0] hi, lo, d,
                        output logic [15:0] q16, r16, output bit ov);
    longint a, b, q, r;
    bit sgn;
    sgn = (m == 3'd1) || (m == 3'd3) || (m == 3'd4);
    case (m)
      3'd1:    a = longint'($signed(lo));
      3'd2:    a = longint'({hi, lo});
      3'd3:    a = longint'($signed({hi, lo}));
      3'd4:    a = longint'($signed(lo)) * 32768;
      default: a = longint'(lo);
    endcase
    b = sgn ? longint'($signed(d)) : longint'(d);
    if (b == 0) begin
      ov = 1'b1; q = 0; r = 0;
    end else begin
      q  = a / b;
      r  = a % b;
      ov = sgn ? (q < -32768 || q > 32767) : (q > 65535);
    end
    q16 = q[15:0];
    r16 = r[15:0];
  endtask

  task automatic runOp(input logic [2:0] m, input logic [15:0] hi, lo, d,
                       input bit pres, input bit inject, input string req);
    logic [15:0] eq, er;
    bit eov;
    int cycles;
    refDiv(m, hi, lo, d, eq, er, eov);
    @(negedge clk);
    mode = m; dividendHi = hi; dividendLo = lo; divisor = d;
    preserve = pres; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after accept", busy, 1);
    cycles = 0;
    while (!done && cycles < 20) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      if (inject && cycles == 2) begin
        start = 1'b1; mode = 3'd0; dividendLo = 16'h1234; divisor = 16'd3;
        preserve = ~pres;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(cycles == 6, inject ? "R8 schedule with extra start" : "R4 six steps", cycles, 6);
    check(flagOv == eov, {req, " R5 ov"}, flagOv, eov);
    if (pres) begin
      if (archKnown) begin
        check(quotient == archQ, "R7 quotient held", quotient, archQ);
        check(remainder == archR, "R7 remainder held", remainder, archR);
      end
    end else if (sideKnown) begin
      check(sideQuotient == sideQ, "R7 side quotient held", sideQuotient, sideQ);
      check(sideRemainder == sideR, "R7 side remainder held", sideRemainder, sideR);
    end
    if (!eov) begin
      logic [15:0] aq, ar;
      aq = pres ? sideQuotient : quotient;
      ar = pres ? sideRemainder : remainder;
      check(aq == eq, {req, " quotient"}, aq, eq);
      check(ar == er, {req, " remainder"}, ar, er);
      check(flagN == eq[15], "R6 N", flagN, eq[15]);
      check(flagZ == (eq == 0), "R6 Z", flagZ, eq == 0);
      check(flagC == (er != 0), "R6 C", flagC, er != 0);
    end
    if (pres) begin sideQ = eq; sideR = er; sideKnown = !eov; end
    else      begin archQ = eq; archR = er; archKnown = !eov; end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R4 done single cycle", done, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busy == 0 && done == 0, "R9 control idle", busy, 0);
    check(quotient == 0 && remainder == 0, "R9 results zero", quotient, 0);
    check(sideQuotient == 0 && sideRemainder == 0, "R9 side zero", sideQuotient, 0);
    check({flagN, flagZ, flagC, flagOv} == 4'b0, "R9 flags zero", {flagN, flagZ, flagC, flagOv}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed cases
    runOp(3'd0, 16'h0, 16'd1000, 16'd7, 1'b0, 1'b0, "R1 u16");
    runOp(3'd0, 16'h0, 16'd3, 16'd5, 1'b0, 1'b0, "R1 zero quotient");
    runOp(3'd6, 16'hFFFF, 16'd65535, 16'd256, 1'b0, 1'b0, "R1 code6 as u16");
    runOp(3'd2, 16'h0001, 16'h0000, 16'd2, 1'b0, 1'b0, "R1 u32");
    runOp(3'd2, 16'h0005, 16'h0000, 16'd5, 1'b0, 1'b0, "R5 u32 too large");
    runOp(3'd1, 16'h0, 16'hFFF9, 16'd2, 1'b0, 1'b0, "R2 s16 neg");
    runOp(3'd1, 16'h0, 16'h8000, 16'hFFFF, 1'b0, 1'b0, "R5 s16 min/-1");
    runOp(3'd3, 16'hFFFE, 16'h7960, 16'd7, 1'b0, 1'b0, "R2 s32");
    runOp(3'd3, 16'h0, 16'd100, 16'h0000, 1'b0, 1'b0, "R5 divide by zero");
    runOp(3'd4, 16'h0, 16'h2000, 16'h4000, 1'b0, 1'b0, "R3 frac");
    runOp(3'd4, 16'h0, 16'h4000, 16'h4000, 1'b0, 1'b0, "R5 frac equal");
    runOp(3'd4, 16'h0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, "R3 frac neg");
    runOp(3'd0, 16'h0, 16'd500, 16'd9, 1'b1, 1'b0, "R7 preserve");
    runOp(3'd0, 16'h0, 16'd77, 16'd10, 1'b0, 1'b0, "R7 normal");
    runOp(3'd3, 16'hFFFF, 16'hFF00, 16'd16, 1'b0, 1'b1, "R8 busy start");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  m;
      logic [15:0] hi, lo, d;
      string       tag;
      m  = 3'($urandom_range(0, 4));
      lo = 16'($urandom);
      d  = 16'($urandom);
      hi = 16'($urandom);
      if (($urandom & 3) != 0) begin
        if (m == 3'd2) hi = hi % ((d == 0) ? 16'd1 : d);
        if (m == 3'd3) hi = {{9{hi[15]}}, hi[6:0]};
      end
      if (($urandom & 15) == 0) d = 16'd0;
      case (m)
        3'd0, 3'd2: tag = "R1 random";
        3'd1, 3'd3: tag = "R2 random";
        default:    tag = "R3 random";
      endcase
      runOp(m, hi, lo, d, bit'($urandom & 1), 1'b0, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule